// File: doc/BRIEF.md
# Memory-Mapped Signed Divider

A peripheral that performs signed integer division for a processor on a 32-bit register bus. Software first loads a divisor. It then supplies a dividend, either as a single 32-bit word or as a 64-bit value split across a high word and a low word. The bus write that completes the dividend starts the operation. A radix-2 restoring sequencer runs on the operand magnitudes, and a fix-up stage applies the signs. The quotient truncates toward zero, and the remainder carries the sign of the dividend.

When the sequencer finishes, the results are written back into several register slots at the same time. Some of these slots are the dividend registers themselves, so a program can chain operations or read the result from whichever slot suits it. While a divide is in progress, a busy bit is set and the unit ignores every bus write. Division by zero, and any quotient that cannot be held in a signed 32-bit value, set a sticky overflow flag and load saturated results.

Top module: `mmdiv_top`

## Requirements
- R1: After reset, every register reads zero, busy is low and the overflow flag is clear.
- R2: A write to byte offset 0x04 while idle starts a signed 32/32 divide of that word by the divisor at offset 0x00. The quotient truncates toward zero and the remainder has the sign of the dividend.
- R3: When a 32/32 divide completes, the remainder appears at offsets 0x10 and 0x18, and the quotient appears at offsets 0x04, 0x14 and 0x1C.
- R4: Offset 0x10 holds the high dividend word. A write to offset 0x14 while idle starts a signed 64/32 divide of {0x10, written word}. On completion the remainder goes to 0x10 and 0x18, the quotient goes to 0x14 and 0x1C, and 0x04 keeps its value.
- R5: busy rises on the clock edge that accepts a starting write and stays high for 34 cycles. The results are loaded on the edge where busy falls.
- R6: While busy is high, all result registers keep the values they had before the start.
- R7: Bus writes to any offset while busy is high are ignored.
- R8: A zero divisor sets the overflow flag, writes a quotient of 0x7FFFFFFF (dividend non-negative) or 0x80000000 (dividend negative), and writes a remainder of 0.
- R9: A non-zero divisor whose true quotient lies outside the signed 32-bit range sets the overflow flag. The quotient becomes 0x7FFFFFFF when the true quotient is positive and 0x80000000 when it is negative, and the remainder becomes 0.
- R10: The control word at offset 0x08 reads the overflow flag in bit 0 and busy in bit 1. The flag is sticky, and writing 1 to bit 0 while idle clears it. Writing 0 to bit 0 leaves it unchanged.
- R11: Offset 0x0C and misaligned addresses read zero and ignore writes. Writes to 0x18 and 0x1C are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Byte offset of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| busy | output | 1 | A divide is in progress |

## Verification
The assertions assume that the bus presents at most one write per cycle and that write fields are stable around the clock edge. They also assume that reset is held for at least one edge before any traffic. The stimulus drives every input just after the falling edge, never asserts a write during reset, and issues starting writes only through a single-write task. Writes that land while busy is high are deliberate and are exercised to confirm that they are ignored.

// File: rtl/mmdiv_pkg.sv
// Package: shared constants and types for the memory-mapped divider.
// Assumes byte offsets within a 32-byte window, word aligned.
package mmdiv_pkg;

    // Word slots of the register window (byte offset / 4)
    localparam int SLOT_DIVISOR = 0;
    localparam int SLOT_DVD32   = 1;
    localparam int SLOT_CTRL    = 2;
    localparam int SLOT_HOLE    = 3;
    localparam int SLOT_HI      = 4;
    localparam int SLOT_LO      = 5;
    localparam int SLOT_REMM    = 6;
    localparam int SLOT_QUOM    = 7;
    localparam int NUM_SLOTS    = 8;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_ITER = 2'd2,
        ST_FIN  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/mmdiv_regfile.sv
// Module: register window of the divider.
// Holds divisor, dividend words and result mirrors, decodes bus writes,
// produces the start pulse and operands, and serves combinational reads.
// Assumes one write per cycle; all writes are dropped while busy.
module mmdiv_regfile
    import mmdiv_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data,
    input  logic            busy,
    input  logic            done,
    input  logic            done_wide,
    input  logic [DW-1:0]   res_quo,
    input  logic [DW-1:0]   res_rem,
    input  logic            res_ovf,
    output logic            start,
    output logic            start_wide,
    output logic [2*DW-1:0] op_num,
    output logic [DW-1:0]   op_den,
    output logic            ovf_flag,
    output logic [DW-1:0]   divisor_q,
    output logic [DW-1:0]   hi_q,
    output logic [DW-1:0]   lo_q,
    output logic [DW-1:0]   remm_q,
    output logic [DW-1:0]   quom_q
);

    logic [NUM_SLOTS-1:0] hit_w;
    logic [NUM_SLOTS-1:0] hit_r;
    logic [DW-1:0]        dvd32_q;
    logic [DW-1:0]        slot_val [NUM_SLOTS];
    logic                 accept;

    // Full-address slot decode for both ports; misaligned offsets hit nothing
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_dec
        assign hit_w[s] = (wr_addr == AW'(s * 4));
        assign hit_r[s] = (rd_addr == AW'(s * 4));
    end

    assign accept     = wr_en && !busy;
    assign start      = accept && (hit_w[SLOT_DVD32] || hit_w[SLOT_LO]);
    assign start_wide = hit_w[SLOT_LO];
    assign op_den     = divisor_q;

    // Assemble the signed dividend for the operation being started
    always_comb begin
        if (hit_w[SLOT_LO]) begin
            op_num = {hi_q, wr_data};
        end else begin
            op_num = {{DW{wr_data[DW-1]}}, wr_data};
        end
    end

    // Divisor register: software writable while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            divisor_q <= '0;
        end else if (accept && hit_w[SLOT_DIVISOR]) begin
            divisor_q <= wr_data;
        end
    end

    // Short dividend register: takes the quotient of narrow divides
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvd32_q <= '0;
        end else if (done && !done_wide) begin
            dvd32_q <= res_quo;
        end else if (accept && hit_w[SLOT_DVD32]) begin
            dvd32_q <= wr_data;
        end
    end

    // High dividend word: takes the remainder of every divide
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else if (done) begin
            hi_q <= res_rem;
        end else if (accept && hit_w[SLOT_HI]) begin
            hi_q <= wr_data;
        end
    end

    // Low dividend word: takes the quotient of every divide
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
        end else if (done) begin
            lo_q <= res_quo;
        end else if (accept && hit_w[SLOT_LO]) begin
            lo_q <= wr_data;
        end
    end

    // Read-only result mirrors: loaded only at completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remm_q <= '0;
            quom_q <= '0;
        end else if (done) begin
            remm_q <= res_rem;
            quom_q <= res_quo;
        end
    end

    // Sticky overflow flag: set by a saturated result, cleared by writing one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
        end else if (done && res_ovf) begin
            ovf_flag <= 1'b1;
        end else if (accept && hit_w[SLOT_CTRL] && wr_data[0]) begin
            ovf_flag <= 1'b0;
        end
    end

    // Values presented on each read slot
    always_comb begin
        slot_val[SLOT_DIVISOR] = divisor_q;
        slot_val[SLOT_DVD32]   = dvd32_q;
        slot_val[SLOT_CTRL]    = {{(DW-2){1'b0}}, busy, ovf_flag};
        slot_val[SLOT_HOLE]    = '0;
        slot_val[SLOT_HI]      = hi_q;
        slot_val[SLOT_LO]      = lo_q;
        slot_val[SLOT_REMM]    = remm_q;
        slot_val[SLOT_QUOM]    = quom_q;
    end

    // Read mux: zero when no slot matches
    always_comb begin
        rd_data = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (hit_r[s]) begin
                rd_data = slot_val[s];
            end
        end
    end

endmodule

// File: rtl/mmdiv_seq.sv
// Module: iterative unsigned restoring divide on operand magnitudes.
// Takes a start pulse with a signed 2*DW-bit dividend and a DW-bit divisor,
// runs one load cycle, DW shift-subtract cycles and one finish cycle.
// Assumes start is only pulsed while idle. Flags a quotient that cannot fit
// DW unsigned bits (including a zero divisor) before iterating.
module mmdiv_seq
    import mmdiv_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            start_wide,
    input  logic [2*DW-1:0] num,
    input  logic [DW-1:0]   den,
    output logic            busy,
    output logic            fin,
    output logic            wide,
    output logic            neg_num,
    output logic            neg_den,
    output logic            pre_ovf,
    output logic [DW-1:0]   qmag,
    output logic [DW-1:0]   rmag
);

    localparam int CW = $clog2(DW);

    seq_state_e        state;
    logic [CW-1:0]     iter_cnt;
    logic [2*DW-1:0]   num_mag;
    logic [DW-1:0]     den_mag;
    logic [DW:0]       shifted;
    logic              take;

    assign busy = (state != ST_IDLE);
    assign fin  = (state == ST_FIN);

    // Trial subtraction for one restoring step
    always_comb begin
        shifted = {rmag, qmag[DW-1]};
        take    = (shifted >= {1'b0, den_mag});
    end

    // Control sequence: idle -> load -> DW iterations -> finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            iter_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) state <= ST_LOAD;
                ST_LOAD: begin
                    state    <= ST_ITER;
                    iter_cnt <= '0;
                end
                ST_ITER: begin
                    iter_cnt <= iter_cnt + 1'b1;
                    if (iter_cnt == CW'(DW - 1)) state <= ST_FIN;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Operand capture: signs and magnitudes latched at start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wide    <= 1'b0;
            neg_num <= 1'b0;
            neg_den <= 1'b0;
            num_mag <= '0;
            den_mag <= '0;
        end else if (state == ST_IDLE && start) begin
            wide    <= start_wide;
            neg_num <= num[2*DW-1];
            neg_den <= den[DW-1];
            num_mag <= num[2*DW-1] ? (~num + 1'b1) : num;
            den_mag <= den[DW-1] ? (~den + 1'b1) : den;
        end
    end

    // Datapath: load partial remainder and quotient, then shift-subtract
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rmag    <= '0;
            qmag    <= '0;
            pre_ovf <= 1'b0;
        end else if (state == ST_LOAD) begin
            rmag    <= num_mag[2*DW-1:DW];
            qmag    <= num_mag[DW-1:0];
            pre_ovf <= (num_mag[2*DW-1:DW] >= den_mag);
        end else if (state == ST_ITER) begin
            rmag <= take ? DW'(shifted - {1'b0, den_mag}) : shifted[DW-1:0];
            qmag <= {qmag[DW-2:0], take};
        end
    end

endmodule

// File: rtl/mmdiv_fixup.sv
// Module: sign restoration and saturation of the raw magnitudes.
// Purely combinational. Assumes pre_ovf already covers a zero divisor and
// any magnitude that does not fit DW bits.
module mmdiv_fixup #(
    parameter int DW = 32
) (
    input  logic          neg_num,
    input  logic          neg_den,
    input  logic          pre_ovf,
    input  logic [DW-1:0] qmag,
    input  logic [DW-1:0] rmag,
    output logic [DW-1:0] quo,
    output logic [DW-1:0] rem,
    output logic          ovf
);

    localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

    logic q_neg;
    logic range_ovf;

    // Signed range check on the unsigned quotient magnitude
    always_comb begin
        q_neg     = neg_num ^ neg_den;
        range_ovf = q_neg ? (qmag > SMIN) : qmag[DW-1];
        ovf       = pre_ovf || range_ovf;
    end

    // Apply signs or saturate
    always_comb begin
        if (ovf) begin
            quo = q_neg ? SMIN : SMAX;
            rem = '0;
        end else begin
            quo = q_neg ? (~qmag + 1'b1) : qmag;
            rem = neg_num ? (~rmag + 1'b1) : rmag;
        end
    end

endmodule

// File: rtl/mmdiv_top.sv
// Module: memory-mapped signed divider, top level.
// Connects the register window, the restoring sequencer and the sign fix-up.
// Assumes a single-master register bus with one write per cycle.
module mmdiv_top #(
    parameter int DW = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          busy
);

    logic            start;
    logic            start_wide;
    logic [2*DW-1:0] op_num;
    logic [DW-1:0]   op_den;
    logic            fin;
    logic            wide;
    logic            neg_num;
    logic            neg_den;
    logic            pre_ovf;
    logic [DW-1:0]   qmag;
    logic [DW-1:0]   rmag;
    logic [DW-1:0]   res_quo;
    logic [DW-1:0]   res_rem;
    logic            res_ovf;
    logic            ovf_flag;
    logic [DW-1:0]   divisor_q;
    logic [DW-1:0]   hi_q;
    logic [DW-1:0]   lo_q;
    logic [DW-1:0]   remm_q;
    logic [DW-1:0]   quom_q;

    mmdiv_regfile #(.DW(DW), .AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .busy       (busy),
        .done       (fin),
        .done_wide  (wide),
        .res_quo    (res_quo),
        .res_rem    (res_rem),
        .res_ovf    (res_ovf),
        .start      (start),
        .start_wide (start_wide),
        .op_num     (op_num),
        .op_den     (op_den),
        .ovf_flag   (ovf_flag),
        .divisor_q  (divisor_q),
        .hi_q       (hi_q),
        .lo_q       (lo_q),
        .remm_q     (remm_q),
        .quom_q     (quom_q)
    );

    mmdiv_seq #(.DW(DW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_wide (start_wide),
        .num        (op_num),
        .den        (op_den),
        .busy       (busy),
        .fin        (fin),
        .wide       (wide),
        .neg_num    (neg_num),
        .neg_den    (neg_den),
        .pre_ovf    (pre_ovf),
        .qmag       (qmag),
        .rmag       (rmag)
    );

    mmdiv_fixup #(.DW(DW)) u_fix (
        .neg_num (neg_num),
        .neg_den (neg_den),
        .pre_ovf (pre_ovf),
        .qmag    (qmag),
        .rmag    (rmag),
        .quo     (res_quo),
        .rem     (res_rem),
        .ovf     (res_ovf)
    );

endmodule

// File: rtl/mmdiv_chk.sv
// Module: assertion checker for the divider, bound to the top level.
// Assumes it observes the register window through the top's internal wires.
module mmdiv_chk #(
    parameter int DW = 32,
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          ovf_flag,
    input logic [DW-1:0] divisor_q,
    input logic [DW-1:0] hi_q,
    input logic [DW-1:0] lo_q,
    input logic [DW-1:0] remm_q,
    input logic [DW-1:0] quom_q
);

    localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

    logic start_wr;
    logic clear_wr;

    assign start_wr = wr_en && (wr_addr == AW'(4) || wr_addr == AW'(20));
    assign clear_wr = wr_en && !busy && (wr_addr == AW'(8)) && wr_data[0];

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_wr) |=> busy);                                         // R5

    AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(quom_q) && $stable(remm_q)));       // R6

    AST_DIVISOR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> $stable(divisor_q));                               // R7

    AST_MIRRORS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (remm_q == hi_q && quom_q == lo_q));                   // R3

    AST_SATURATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> (remm_q == '0 && (quom_q == SMAX || quom_q == SMIN))); // R8

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clear_wr) |=> ovf_flag);                                 // R10

endmodule

bind mmdiv_top mmdiv_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .ovf_flag  (ovf_flag),
    .divisor_q (divisor_q),
    .hi_q      (hi_q),
    .lo_q      (lo_q),
    .remm_q    (remm_q),
    .quom_q    (quom_q)
);

// File: tb/mmdiv_top_tb_top.sv
// Bench: behavioural reference model compared every cycle, plus directed checks.
module mmdiv_top_tb_top;

    localparam int LAT = 34;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        busy;

    int checks = 0;
    int errors = 0;

    // Reference state
    logic [31:0] m [8];
    int          cnt = 0;
    logic        movf = 1'b0;
    logic [31:0] p_q, p_r;
    logic        p_ovf, p_wide;

    always #5 clk = ~clk;

    mmdiv_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );

    function automatic void ref_div(input longint n, input int d,
                                    output logic [31:0] q, output logic [31:0] r,
                                    output logic ov);
        longint qq, rr;
        ov = 1'b0; q = '0; r = '0;
        if (d == 0) begin
            ov = 1'b1; q = (n < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
        end else if (d == -1 && n == 64'sh8000_0000_0000_0000) begin
            ov = 1'b1; q = 32'h7FFF_FFFF;
        end else begin
            qq = n / longint'(d);
            rr = n % longint'(d);
            if (qq > 64'sd2147483647 || qq < -64'sd2147483648) begin
                ov = 1'b1; q = (qq < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
            end else begin
                q = qq[31:0]; r = rr[31:0];
            end
        end
    endfunction

    function automatic logic [31:0] exp_rd(input logic [4:0] a);
        case (a)
            5'h00: return m[0];
            5'h04: return m[1];
            5'h08: return {30'b0, cnt > 0, movf};
            5'h10: return m[4];
            5'h14: return m[5];
            5'h18: return m[6];
            5'h1C: return m[7];
            default: return 32'h0;
        endcase
    endfunction

    // Reference model update on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) m[i] = '0;
            cnt = 0; movf = 1'b0;
        end else if (cnt > 0) begin
            cnt = cnt - 1;
            if (cnt == 0) begin
                m[4] = p_r; m[6] = p_r; m[5] = p_q; m[7] = p_q;
                if (!p_wide) m[1] = p_q;
                if (p_ovf) movf = 1'b1;
            end
        end else if (wr_en) begin
            case (wr_addr)
                5'h00: m[0] = wr_data;
                5'h04: begin
                    ref_div(longint'($signed(wr_data)), int'($signed(m[0])), p_q, p_r, p_ovf);
                    m[1] = wr_data; p_wide = 1'b0; cnt = LAT;
                end
                5'h08: if (wr_data[0]) movf = 1'b0;
                5'h10: m[4] = wr_data;
                5'h14: begin
                    ref_div($signed({m[4], wr_data}), int'($signed(m[0])), p_q, p_r, p_ovf);
                    m[5] = wr_data; p_wide = 1'b1; cnt = LAT;
                end
                default: ;
            endcase
        end
    end

    // Cycle compare on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (busy !== (cnt > 0)) begin
                errors++;
                $display("FAIL R5 busy: actual %0b expected %0b", busy, cnt > 0);
            end
            checks++;
            if (rd_data !== exp_rd(rd_addr)) begin
                errors++;
                $display("FAIL R2 read @%h: actual %h expected %h", rd_addr, rd_data, exp_rd(rd_addr));
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [31:0] e, input string tag);
        @(negedge clk); #1;
        rd_addr = a;
        #2;
        checks++;
        if (rd_data !== e) begin
            errors++;
            $display("FAIL %s read @%h: actual %h expected %h", tag, a, rd_data, e);
        end
    endtask

    task automatic busy_chk(input logic e, input string tag);
        #1;
        checks++;
        if (busy !== e) begin
            errors++;
            $display("FAIL %s busy: actual %0b expected %0b", tag, busy, e);
        end
    endtask

    task automatic wait_idle();
        repeat (LAT + 2) @(negedge clk);
    endtask

    initial begin : watchdog
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        for (int a = 0; a < 32; a += 4) rd_chk(5'(a), 32'h0, "R1");
        busy_chk(1'b0, "R1");

        // R2 R3: -7 / 2
        wr(5'h00, 32'd2);
        wr(5'h04, 32'hFFFF_FFF9);
        busy_chk(1'b1, "R5");
        wait_idle();
        busy_chk(1'b0, "R5");
        rd_chk(5'h04, 32'hFFFF_FFFD, "R3");
        rd_chk(5'h14, 32'hFFFF_FFFD, "R3");
        rd_chk(5'h1C, 32'hFFFF_FFFD, "R2");
        rd_chk(5'h10, 32'hFFFF_FFFF, "R3");
        rd_chk(5'h18, 32'hFFFF_FFFF, "R2");

        // R2: 7 / -2
        wr(5'h00, 32'hFFFF_FFFE);
        wr(5'h04, 32'd7);
        wait_idle();
        rd_chk(5'h1C, 32'hFFFF_FFFD, "R2");
        rd_chk(5'h18, 32'd1, "R2");

        // R6 R7: 100 / 7 with a write during busy
        wr(5'h00, 32'd7);
        wr(5'h04, 32'd100);
        rd_chk(5'h1C, 32'hFFFF_FFFD, "R6");
        rd_chk(5'h08, 32'h2, "R10");
        wr(5'h00, 32'd5);
        wait_idle();
        rd_chk(5'h1C, 32'd14, "R2");
        rd_chk(5'h10, 32'd2, "R3");
        rd_chk(5'h00, 32'd7, "R7");

        // R4: 64/32 positive
        wr(5'h00, 32'd16);
        wr(5'h10, 32'd1);
        wr(5'h14, 32'd4);
        wait_idle();
        rd_chk(5'h14, 32'h1000_0000, "R4");
        rd_chk(5'h1C, 32'h1000_0000, "R4");
        rd_chk(5'h10, 32'd4, "R4");
        rd_chk(5'h04, 32'd14, "R4");

        // R4: 64/32 negative, -16 / 3
        wr(5'h00, 32'd3);
        wr(5'h10, 32'hFFFF_FFFF);
        wr(5'h14, 32'hFFFF_FFF0);
        wait_idle();
        rd_chk(5'h14, 32'hFFFF_FFFB, "R4");
        rd_chk(5'h18, 32'hFFFF_FFFF, "R4");

        // R8: divide by zero with negative dividend
        wr(5'h00, 32'd0);
        wr(5'h04, 32'hFFFF_FFFB);
        wait_idle();
        rd_chk(5'h1C, 32'h8000_0000, "R8");
        rd_chk(5'h18, 32'h0, "R8");
        rd_chk(5'h08, 32'h1, "R10");

        // R10: writing 0 keeps the flag, writing 1 clears it
        wr(5'h08, 32'h0);
        rd_chk(5'h08, 32'h1, "R10");
        wr(5'h08, 32'h1);
        rd_chk(5'h08, 32'h0, "R10");

        // R9: 64/32 quotient too large
        wr(5'h00, 32'd1);
        wr(5'h10, 32'd1);
        wr(5'h14, 32'd0);
        wait_idle();
        rd_chk(5'h1C, 32'h7FFF_FFFF, "R9");
        rd_chk(5'h10, 32'h0, "R9");
        rd_chk(5'h08, 32'h1, "R9");
        wr(5'h08, 32'h1);

        // R9: most negative / -1
        wr(5'h00, 32'hFFFF_FFFF);
        wr(5'h04, 32'h8000_0000);
        wait_idle();
        rd_chk(5'h04, 32'h7FFF_FFFF, "R9");
        rd_chk(5'h08, 32'h1, "R9");

        // R11: holes, misaligned and read-only slots
        wr(5'h1C, 32'd1234);
        rd_chk(5'h1C, 32'h7FFF_FFFF, "R11");
        wr(5'h18, 32'd99);
        rd_chk(5'h18, 32'h0, "R11");
        wr(5'h0C, 32'd77);
        rd_chk(5'h0C, 32'h0, "R11");
        wr(5'h01, 32'd55);
        rd_chk(5'h00, 32'hFFFF_FFFF, "R11");
        rd_chk(5'h02, 32'h0, "R11");

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule